// File: doc/BRIEF.md
# Selectable ADC Sample Format Converter

This block turns raw ADC samples into signed two's-complement values in the fast sampling clock domain. Some converters send offset-binary codes and others send two's-complement codes. A 2-bit format code selects the conversion rule, so the same logic can serve either kind of converter without a rebuild.

A host sets the format code in a slower control clock domain. It does this by issuing a write strobe together with an opcode byte and a data byte. Only one opcode loads the format register. The register value crosses into the sampling domain through a two-flop synchronizer. From there it steers a registered per-sample converter, which has one cycle of latency and a valid flag. The reserved codes give a defined fallback, the same offset-binary rule used at reset.

Top module: `adc_fmt_conv`

## Requirements
- R1: After reset, the format is offset-binary, `smp_valid_out` is 0 and `smp_out` is 0.
- R2: In offset-binary mode (code 2'b00), `smp_out` is the input with bit 7 inverted. So 0x80 gives 0, 0x00 gives -128 (0x80), and 0xFF gives +127 (0x7F).
- R3: In two's-complement mode (code 2'b01), `smp_out` equals the input unchanged. So 0x00 gives 0, 0x80 gives -128, and 0x7F gives +127.
- R4: Codes 2'b10 and 2'b11 are reserved. Both convert exactly as offset-binary does.
- R5: The format register loads `cmd_data[1:0]` only on a clock where `cmd_wr` is 1 and `cmd_opcode` is 0x33. Any other opcode, including 0x32, leaves the format unchanged. A strobe of 0 also leaves it unchanged.
- R6: `smp_valid_out` equals `smp_valid_in` delayed by one sampling clock. When `smp_valid_in` is 0, `smp_out` holds its previous value.
- R7: A new format code reaches the converter through two sampling-domain flops. A sample presented four or more sampling clocks after the control-domain register update uses the new rule.
- R8: Each domain has its own active-high synchronous reset. `rst_ctrl` returns the host register to 2'b00. `rst_smp` returns the synchronizer stages and the output registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctrl | input | 1 | Control-domain clock |
| rst_ctrl | input | 1 | Active-high synchronous reset, control domain |
| cmd_wr | input | 1 | Host command write strobe |
| cmd_opcode | input | 8 | Host command opcode |
| cmd_data | input | 8 | Host command data byte; bits 1:0 carry the format code |
| clk_smp | input | 1 | Sampling-domain clock |
| rst_smp | input | 1 | Active-high synchronous reset, sampling domain |
| smp_valid_in | input | 1 | Input sample valid |
| smp_in | input | 8 | Raw ADC sample |
| smp_valid_out | output | 1 | Output sample valid, one cycle after input |
| smp_out | output | 8 | Signed two's-complement sample |

## Verification
A wrong format register or synchronizer stage shows up as a sample with bit 7 flipped. It appears on `smp_out` one sampling clock after the first valid sample that follows the wrong state. The bench probes the edge codes 0x00, 0x7F, 0x80 and 0xFF, because bit 7 differs between the two rules at each of them. A command decoder that accepts the wrong opcode is caught on the next probe sample. A faulty valid pipeline shows on `smp_valid_out` at the very next sampling edge.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int FMT_W = 2;

  typedef enum logic [FMT_W-1:0] {
    FMT_OFFSET = 2'b00,
    FMT_TWOS   = 2'b01,
    FMT_RSV_A  = 2'b10,
    FMT_RSV_B  = 2'b11
  } fmt_e;

  localparam logic [FMT_W-1:0] FMT_RESET = FMT_OFFSET;
endpackage

// File: rtl/adc_fmt_host_reg.sv
module adc_fmt_host_reg #(
  parameter int OP_W = 8,
  parameter int DATA_W = 8,
  parameter logic [OP_W-1:0] FMT_OPCODE = 8'h33
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic [OP_W-1:0]               opcode,
  input  logic [DATA_W-1:0]             data,
  output logic [adc_fmt_pkg::FMT_W-1:0] fmt
);
  import adc_fmt_pkg::*;

  logic hit;

  // only the assigned opcode touches the format register; every other code is inert
  always_comb hit = wr && (opcode == FMT_OPCODE);

  always_ff @(posedge clk) begin
    if (rst)      fmt <= FMT_RESET;
    else if (hit) fmt <= data[FMT_W-1:0];
  end
endmodule

// File: rtl/adc_fmt_sync.sv
module adc_fmt_sync #(
  parameter int W = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= '0;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/adc_fmt_convert.sv
module adc_fmt_convert #(
  parameter int SMP_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [adc_fmt_pkg::FMT_W-1:0] fmt,
  input  logic                          vld_i,
  input  logic [SMP_W-1:0]              smp_i,
  output logic                          vld_o,
  output logic [SMP_W-1:0]              smp_o
);
  import adc_fmt_pkg::*;

  localparam logic [SMP_W-1:0] MSB_MASK = {1'b1, {(SMP_W-1){1'b0}}};

  logic [SMP_W-1:0] conv;

  // two's-complement input passes straight through; the default and both reserved codes flip the sign bit
  always_comb begin
    case (fmt_e'(fmt))
      FMT_TWOS: conv = smp_i;
      default:  conv = smp_i ^ MSB_MASK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o <= 1'b0;
      smp_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) smp_o <= conv;
    end
  end
endmodule

// File: rtl/adc_fmt_conv.sv
module adc_fmt_conv #(
  parameter int SMP_W = 8,
  parameter int OP_W = 8,
  parameter int DATA_W = 8,
  parameter logic [OP_W-1:0] FMT_OPCODE = 8'h33,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_ctrl,
  input  logic              rst_ctrl,
  input  logic              cmd_wr,
  input  logic [OP_W-1:0]   cmd_opcode,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              clk_smp,
  input  logic              rst_smp,
  input  logic              smp_valid_in,
  input  logic [SMP_W-1:0]  smp_in,
  output logic              smp_valid_out,
  output logic [SMP_W-1:0]  smp_out
);
  import adc_fmt_pkg::*;

  logic [FMT_W-1:0] host_fmt;
  logic [FMT_W-1:0] smp_fmt;

  adc_fmt_host_reg #(
    .OP_W(OP_W), .DATA_W(DATA_W), .FMT_OPCODE(FMT_OPCODE)
  ) u_host (
    .clk(clk_ctrl), .rst(rst_ctrl), .wr(cmd_wr),
    .opcode(cmd_opcode), .data(cmd_data), .fmt(host_fmt)
  );

  adc_fmt_sync #(
    .W(FMT_W), .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk_smp), .rst(rst_smp), .d(host_fmt), .q(smp_fmt)
  );

  adc_fmt_convert #(
    .SMP_W(SMP_W)
  ) u_conv (
    .clk(clk_smp), .rst(rst_smp), .fmt(smp_fmt),
    .vld_i(smp_valid_in), .smp_i(smp_in),
    .vld_o(smp_valid_out), .smp_o(smp_out)
  );
endmodule

// File: rtl/adc_fmt_conv_chk.sv
module adc_fmt_conv_chk #(
  parameter int SMP_W = 8,
  parameter int OP_W = 8,
  parameter int DATA_W = 8,
  parameter logic [OP_W-1:0] FMT_OPCODE = 8'h33
) (
  input logic              clk_ctrl,
  input logic              rst_ctrl,
  input logic              cmd_wr,
  input logic [OP_W-1:0]   cmd_opcode,
  input logic [DATA_W-1:0] cmd_data,
  input logic              clk_smp,
  input logic              rst_smp,
  input logic              smp_valid_in,
  input logic [SMP_W-1:0]  smp_in,
  input logic              smp_valid_out,
  input logic [SMP_W-1:0]  smp_out,
  input logic [1:0]        host_fmt,
  input logic [1:0]        smp_fmt
);
  localparam logic [SMP_W-1:0] MSB_MASK = {1'b1, {(SMP_W-1){1'b0}}};

  assert_ctrl_reset_R8: assert property (@(posedge clk_ctrl)
    rst_ctrl |=> host_fmt == 2'b00);

  assert_smp_reset_R1: assert property (@(posedge clk_smp)
    rst_smp |=> (smp_fmt == 2'b00 && !smp_valid_out && smp_out == '0));

  assert_load_R5: assert property (@(posedge clk_ctrl) disable iff (rst_ctrl)
    (cmd_wr && cmd_opcode == FMT_OPCODE) |=> host_fmt == $past(cmd_data[1:0]));

  assert_ignore_R5: assert property (@(posedge clk_ctrl) disable iff (rst_ctrl)
    !(cmd_wr && cmd_opcode == FMT_OPCODE) |=> $stable(host_fmt));

  assert_valid_rise_R6: assert property (@(posedge clk_smp) disable iff (rst_smp)
    smp_valid_in |=> smp_valid_out);

  assert_valid_low_R6: assert property (@(posedge clk_smp) disable iff (rst_smp)
    !smp_valid_in |=> !smp_valid_out);

  assert_hold_R6: assert property (@(posedge clk_smp) disable iff (rst_smp)
    !smp_valid_in |=> $stable(smp_out));

  assert_twos_R3: assert property (@(posedge clk_smp) disable iff (rst_smp)
    (smp_valid_in && smp_fmt == 2'b01) |=> smp_out == $past(smp_in));

  assert_offset_R2: assert property (@(posedge clk_smp) disable iff (rst_smp)
    (smp_valid_in && smp_fmt == 2'b00) |=> smp_out == ($past(smp_in) ^ MSB_MASK));

  assert_reserved_R4: assert property (@(posedge clk_smp) disable iff (rst_smp)
    (smp_valid_in && smp_fmt[1]) |=> smp_out == ($past(smp_in) ^ MSB_MASK));
endmodule

bind adc_fmt_conv adc_fmt_conv_chk #(
  .SMP_W(SMP_W), .OP_W(OP_W), .DATA_W(DATA_W), .FMT_OPCODE(FMT_OPCODE)
) u_chk (
  .clk_ctrl(clk_ctrl), .rst_ctrl(rst_ctrl), .cmd_wr(cmd_wr),
  .cmd_opcode(cmd_opcode), .cmd_data(cmd_data),
  .clk_smp(clk_smp), .rst_smp(rst_smp),
  .smp_valid_in(smp_valid_in), .smp_in(smp_in),
  .smp_valid_out(smp_valid_out), .smp_out(smp_out),
  .host_fmt(host_fmt), .smp_fmt(smp_fmt)
);

// File: tb/tb_adc_fmt_conv.sv
`timescale 1ns/1ps
module tb_adc_fmt_conv;
  logic       clk_ctrl = 1'b0;
  logic       clk_smp = 1'b0;
  logic       rst_ctrl = 1'b1;
  logic       rst_smp = 1'b1;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_opcode = '0;
  logic [7:0] cmd_data = '0;
  logic       smp_valid_in = 1'b0;
  logic [7:0] smp_in = '0;
  logic       smp_valid_out;
  logic [7:0] smp_out;

  int checks = 0;
  int errors = 0;

  always #5.0 clk_ctrl = ~clk_ctrl;
  always #1.25 clk_smp = ~clk_smp;

  adc_fmt_conv dut (
    .clk_ctrl(clk_ctrl), .rst_ctrl(rst_ctrl), .cmd_wr(cmd_wr),
    .cmd_opcode(cmd_opcode), .cmd_data(cmd_data),
    .clk_smp(clk_smp), .rst_smp(rst_smp),
    .smp_valid_in(smp_valid_in), .smp_in(smp_in),
    .smp_valid_out(smp_valid_out), .smp_out(smp_out)
  );

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] op, input logic [7:0] dat);
    @(negedge clk_ctrl);
    cmd_wr = 1'b1; cmd_opcode = op; cmd_data = dat;
    @(negedge clk_ctrl);
    cmd_wr = 1'b0; cmd_opcode = '0; cmd_data = '0;
    repeat (6) @(negedge clk_smp);
  endtask

  // drives one valid sample, then reads the registered result one edge later
  task automatic probe(input string req, input logic [7:0] x, input logic [7:0] exp);
    @(negedge clk_smp);
    smp_valid_in = 1'b1; smp_in = x;
    @(negedge clk_smp);
    smp_valid_in = 1'b0; smp_in = ~x;
    check(req, {smp_valid_out, smp_out}, {1'b1, exp});
  endtask

  task automatic do_reset();
    rst_ctrl = 1'b1; rst_smp = 1'b1;
    repeat (3) @(negedge clk_ctrl);
    rst_ctrl = 1'b0; rst_smp = 1'b0;
    @(negedge clk_smp);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 reset outputs", {smp_valid_out, smp_out}, 9'h000);
    probe("R1 default offset", 8'h80, 8'h00);
  endtask

  task automatic t_offset();
    host_write(8'h33, 8'h00);
    probe("R2 0x80", 8'h80, 8'h00);
    probe("R2 0x00", 8'h00, 8'h80);
    probe("R2 0xFF", 8'hFF, 8'h7F);
    probe("R2 0x3C", 8'h3C, 8'hBC);
  endtask

  task automatic t_twos();
    host_write(8'h33, 8'h01);
    probe("R3 0x00", 8'h00, 8'h00);
    probe("R3 0x80", 8'h80, 8'h80);
    probe("R3 0x7F", 8'h7F, 8'h7F);
  endtask

  task automatic t_reserved();
    host_write(8'h33, 8'h02);
    probe("R4 code10 0x80", 8'h80, 8'h00);
    probe("R4 code10 0xFF", 8'hFF, 8'h7F);
    host_write(8'h33, 8'h07);
    probe("R4 code11 0x00", 8'h00, 8'h80);
  endtask

  task automatic t_opcode_filter();
    host_write(8'h33, 8'hFD);
    probe("R5 upper data bits ignored", 8'h80, 8'h80);
    host_write(8'h32, 8'h00);
    probe("R5 opcode 0x32 ignored", 8'h80, 8'h80);
    host_write(8'h34, 8'h00);
    probe("R5 opcode 0x34 ignored", 8'h00, 8'h00);
    @(negedge clk_ctrl);
    cmd_wr = 1'b0; cmd_opcode = 8'h33; cmd_data = 8'h00;
    repeat (2) @(negedge clk_ctrl);
    cmd_opcode = '0;
    repeat (6) @(negedge clk_smp);
    probe("R5 no strobe ignored", 8'h7F, 8'h7F);
  endtask

  task automatic t_valid_pipe();
    logic [7:0] held;
    probe("R6 latency", 8'h5A, 8'h5A);
    held = smp_out;
    @(negedge clk_smp);
    check("R6 valid drops", {8'h00, smp_valid_out}, 9'h000);
    check("R6 data holds", {1'b0, smp_out}, {1'b0, held});
    @(negedge clk_smp);
    smp_valid_in = 1'b1; smp_in = 8'h11;
    @(posedge clk_smp);
    #0.1;
    check("R6 valid rises after one edge", {8'h00, smp_valid_out}, 9'h001);
    @(negedge clk_smp);
    smp_valid_in = 1'b0;
  endtask

  task automatic t_sync_delay();
    @(negedge clk_ctrl);
    cmd_wr = 1'b1; cmd_opcode = 8'h33; cmd_data = 8'h00;
    @(posedge clk_ctrl);
    #0.1;
    cmd_wr = 1'b0; cmd_opcode = '0; cmd_data = '0;
    repeat (3) @(negedge clk_smp);
    probe("R7 new format after sync", 8'h80, 8'h00);
  endtask

  task automatic t_midrun_reset();
    host_write(8'h33, 8'h01);
    probe("R8 pre-reset twos", 8'h80, 8'h80);
    do_reset();
    check("R8 outputs cleared", {smp_valid_out, smp_out}, 9'h000);
    probe("R8 offset after reset", 8'h80, 8'h00);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired before completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_offset();
    t_twos();
    t_reserved();
    t_opcode_filter();
    t_valid_pipe();
    t_sync_delay();
    t_midrun_reset();
    repeat (4) @(negedge clk_smp);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule